// File: doc/BRIEF.md
# Instruction Window Decoder with Effective-Address Adder

This block is the purely combinational front end of a simple processor's execute path. It receives a ten-byte window of fetched instruction bytes, starting at the current instruction, together with the two operand values the register file returned. From these it derives the opcode nibbles and register specifiers, the control flags that steer the rest of the datapath, the sign-extended 32-bit immediate, the effective address used by address-calculation and memory-move instructions, and the byte length of the instruction so the fetch logic can advance.

Window byte k sits at bits 8k+7 down to 8k of the window input. The major opcode selects the instruction class. For the classes that form an address, the low three bits of the minor opcode choose which terms enter the address sum. The first read port's operand is shifted left by a four-bit amount taken from the instruction before it is added. The register file, memory and program-counter update are outside this block; it only produces the port select and the enables that drive them.

Top module: `vlid_decode_agen`

## Requirements
- R1: Byte 0 bits 7:4 give the major opcode and bits 3:0 the minor opcode. Byte 1 bits 7:4 give the destination register and bits 3:0 the source register. Byte 2 bits 7:4 give the index register and bits 3:0 the shift amount.
- R2: Major opcodes 0xC, 0xD and 0xE are undefined. They raise `illegal` and drive every enable and flow flag low. Every other major opcode leaves `illegal` low.
- R3: The immediate is four little-endian bytes that start at byte 3 for major 0xB, at byte 6 for major 0xF and at byte 2 for all other majors. It is sign-extended from bit 31 to the full operand width.
- R4: The address-forming classes are majors 2, 3, 6, 7, 8, 9, 0xA and 0xB. For these, minor bit 0 adds the source operand, minor bit 1 adds the shifted first-port operand and minor bit 2 adds the immediate. A term whose bit is clear contributes zero. Every other class yields an effective address of zero and `use_agen` low.
- R5: The effective address is (first-port operand << shift amount) + source operand + immediate, taken modulo 2^64.
- R6: The first read port selects the index register for majors 8 to 0xB and the destination register for all other majors.
- R7: `reg_wr_en` is high for majors 1, 2, 5, 6 and 8 to 0xB, for loads and for calls, and low otherwise.
- R8: For memory moves (majors 3 and 7), minor bit 3 clear is a load (`mem_rd_en`), and minor bit 3 set is a store (`mem_wr_en`). Both enables are low for all other majors.
- R9: Under major 0, minor 0 is stop and minor 1 is return. Under major 4, minor 0xF is jump, minor 0xE is call and any other minor is a conditional branch. Major 0xF is always a conditional branch. At most one of these flags is high.
- R10: `inst_len` is 2 for majors 0 to 3, 6 for majors 4 to 7, 9 and 0xA, 3 for major 8, 7 for major 0xB, 10 for major 0xF and 0 for an undefined major.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_win | input | 80 | Instruction bytes; byte k at bits 8k+7:8k |
| port_a_val | input | 64 | Operand read through the first register port |
| port_s_val | input | 64 | Operand read through the source register port |
| major_op | output | 4 | Major opcode field |
| minor_op | output | 4 | Minor opcode field |
| reg_d | output | 4 | Destination register field |
| reg_s | output | 4 | Source register field |
| reg_z | output | 4 | Index register field |
| shift_amt | output | 4 | Shift amount field |
| port_a_sel | output | 4 | Register number for the first read port |
| imm_sext | output | 64 | Sign-extended immediate |
| eff_addr | output | 64 | Effective address |
| inst_len | output | 4 | Instruction length in bytes |
| reg_wr_en | output | 1 | Register write enable |
| mem_rd_en | output | 1 | Load enable |
| mem_wr_en | output | 1 | Store enable |
| use_agen | output | 1 | Instruction uses the address adder |
| is_stop | output | 1 | Stop instruction |
| is_ret | output | 1 | Return instruction |
| is_jump | output | 1 | Unconditional jump |
| is_call | output | 1 | Call |
| is_cbranch | output | 1 | Conditional branch |
| illegal | output | 1 | Undefined major opcode |

## Verification
The assertions check, on every input change, that an undefined opcode leaves all enables quiet and reports length zero, that load and store never assert together, that at most one flow flag is high, that non-address classes produce a zero address, that the upper immediate bits copy bit 31, and that the port select follows the major class. Only the bench's scenarios can show the actual values. These include the immediate taken from the right byte offset in each class, the exact sums for each combination of minor term bits, wraparound at the top of the address range with the largest shift, and the length and write-enable tables for every major. Those scenarios compare results against a model written from the requirements.

// File: rtl/vlid_pkg.sv
// Package: shared opcode constants and the decoded control bundle.
// Assumes a 4-bit major and minor opcode and a 4-bit length field.
package vlid_pkg;

    localparam logic [3:0] MJ_RET_STOP  = 4'h0;
    localparam logic [3:0] MJ_REG_ARITH = 4'h1;
    localparam logic [3:0] MJ_REG_MOVE  = 4'h2;
    localparam logic [3:0] MJ_REG_MEM   = 4'h3;
    localparam logic [3:0] MJ_CFLOW     = 4'h4;
    localparam logic [3:0] MJ_IMM_ARITH = 4'h5;
    localparam logic [3:0] MJ_IMM_MOVE  = 4'h6;
    localparam logic [3:0] MJ_IMM_MEM   = 4'h7;
    localparam logic [3:0] MJ_AG_SHORT  = 4'h8;
    localparam logic [3:0] MJ_AG_IMM_A  = 4'h9;
    localparam logic [3:0] MJ_AG_IMM_B  = 4'hA;
    localparam logic [3:0] MJ_AG_LONG   = 4'hB;
    localparam logic [3:0] MJ_CMP_BR    = 4'hF;

    localparam logic [3:0] MN_STOP = 4'h0;
    localparam logic [3:0] MN_RET  = 4'h1;
    localparam logic [3:0] MN_CALL = 4'hE;
    localparam logic [3:0] MN_JUMP = 4'hF;

    // Which byte offset the immediate begins at.
    typedef enum logic [1:0] {
        IMM_AT2 = 2'd0,
        IMM_AT3 = 2'd1,
        IMM_AT6 = 2'd2
    } imm_pos_e;

    typedef struct packed {
        logic       illegal;
        logic       use_agen;
        logic       use_s;
        logic       use_z;
        logic       use_d;
        logic       sel_z_port;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       stop;
        logic       ret;
        logic       jump;
        logic       call;
        logic       cbranch;
        imm_pos_e   imm_pos;
        logic [3:0] len;
    } ctrl_t;

endpackage

// File: rtl/vlid_ctrl_decode.sv
// Control decoder: maps major/minor opcodes to the control bundle,
// the immediate position and the instruction length.
// Assumes undefined majors must leave every enable low.
module vlid_ctrl_decode
    import vlid_pkg::*;
(
    input  logic [3:0] major,
    input  logic [3:0] minor,
    output ctrl_t      ctrl
);

    logic agen_cls;

    // Purpose: classify the opcode and build all control outputs.
    always_comb begin
        ctrl         = '0;
        ctrl.imm_pos = IMM_AT2;
        agen_cls     = 1'b0;
        case (major)
            MJ_RET_STOP: begin
                ctrl.len  = 4'd2;
                ctrl.stop = (minor == MN_STOP);
                ctrl.ret  = (minor == MN_RET);
            end
            MJ_REG_ARITH: begin
                ctrl.len    = 4'd2;
                ctrl.reg_wr = 1'b1;
            end
            MJ_REG_MOVE: begin
                ctrl.len    = 4'd2;
                ctrl.reg_wr = 1'b1;
                agen_cls    = 1'b1;
            end
            MJ_REG_MEM: begin
                ctrl.len    = 4'd2;
                agen_cls    = 1'b1;
                ctrl.mem_rd = ~minor[3];
                ctrl.mem_wr = minor[3];
                ctrl.reg_wr = ~minor[3];
            end
            MJ_CFLOW: begin
                ctrl.len     = 4'd6;
                ctrl.call    = (minor == MN_CALL);
                ctrl.jump    = (minor == MN_JUMP);
                ctrl.cbranch = (minor != MN_CALL) && (minor != MN_JUMP);
                ctrl.reg_wr  = (minor == MN_CALL);
            end
            MJ_IMM_ARITH: begin
                ctrl.len    = 4'd6;
                ctrl.reg_wr = 1'b1;
            end
            MJ_IMM_MOVE: begin
                ctrl.len    = 4'd6;
                ctrl.reg_wr = 1'b1;
                agen_cls    = 1'b1;
            end
            MJ_IMM_MEM: begin
                ctrl.len    = 4'd6;
                agen_cls    = 1'b1;
                ctrl.mem_rd = ~minor[3];
                ctrl.mem_wr = minor[3];
                ctrl.reg_wr = ~minor[3];
            end
            MJ_AG_SHORT: begin
                ctrl.len        = 4'd3;
                ctrl.reg_wr     = 1'b1;
                ctrl.sel_z_port = 1'b1;
                agen_cls        = 1'b1;
            end
            MJ_AG_IMM_A, MJ_AG_IMM_B: begin
                ctrl.len        = 4'd6;
                ctrl.reg_wr     = 1'b1;
                ctrl.sel_z_port = 1'b1;
                agen_cls        = 1'b1;
            end
            MJ_AG_LONG: begin
                ctrl.len        = 4'd7;
                ctrl.imm_pos    = IMM_AT3;
                ctrl.reg_wr     = 1'b1;
                ctrl.sel_z_port = 1'b1;
                agen_cls        = 1'b1;
            end
            MJ_CMP_BR: begin
                ctrl.len     = 4'd10;
                ctrl.imm_pos = IMM_AT6;
                ctrl.cbranch = 1'b1;
            end
            default: begin
                ctrl.illegal = 1'b1;
            end
        endcase
        ctrl.use_agen = agen_cls;
        ctrl.use_s    = agen_cls & minor[0];
        ctrl.use_z    = agen_cls & minor[1];
        ctrl.use_d    = agen_cls & minor[2];
    end

endmodule

// File: rtl/vlid_imm_select.sv
// Immediate selector: picks the little-endian immediate at one of the
// supported byte offsets and sign-extends it to the operand width.
// Assumes the window is long enough for the furthest offset.
module vlid_imm_select
    import vlid_pkg::*;
#(
    parameter int WIN_BYTES = 10,
    parameter int IMM_W     = 32,
    parameter int XLEN      = 64
) (
    input  logic [WIN_BYTES*8-1:0] win,
    input  imm_pos_e               pos,
    output logic [XLEN-1:0]        imm_out
);

    localparam int NPOS = 3;
    localparam int OFFS [NPOS] = '{2, 3, 6};

    logic [IMM_W-1:0] cand [NPOS];
    logic [IMM_W-1:0] picked;

    // Purpose: slice one candidate immediate per supported offset.
    for (genvar gi = 0; gi < NPOS; gi++) begin : g_cand
        assign cand[gi] = win[OFFS[gi]*8 +: IMM_W];
    end

    // Purpose: choose the candidate for this opcode class.
    always_comb begin
        case (pos)
            IMM_AT3: picked = cand[1];
            IMM_AT6: picked = cand[2];
            default: picked = cand[0];
        endcase
    end

    assign imm_out = {{(XLEN-IMM_W){picked[IMM_W-1]}}, picked};

endmodule

// File: rtl/vlid_agen.sv
// Address generator: sums the gated shifted operand, source operand and
// immediate. Assumes unselected terms must contribute zero; wraps at 2^XLEN.
module vlid_agen #(
    parameter int XLEN  = 64,
    parameter int SH_W  = 4
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_s,
    input  logic [XLEN-1:0] imm,
    input  logic [SH_W-1:0] shamt,
    input  logic            en_z,
    input  logic            en_s,
    input  logic            en_d,
    output logic [XLEN-1:0] addr
);

    logic [XLEN-1:0] term_a;
    logic [XLEN-1:0] term_s;
    logic [XLEN-1:0] term_i;

    // Purpose: gate each term and add them modulo 2^XLEN.
    always_comb begin
        term_a = en_z ? (opnd_a << shamt) : '0;
        term_s = en_s ? opnd_s : '0;
        term_i = en_d ? imm : '0;
        addr   = term_a + term_s + term_i;
    end

endmodule

// File: rtl/vlid_decode_agen.sv
// Top: splits the instruction window into fields and wires the decoder,
// immediate selector and address generator together. Fully combinational.
// Assumes the window starts at the first byte of the instruction.
module vlid_decode_agen
    import vlid_pkg::*;
#(
    parameter int WIN_BYTES = 10,
    parameter int XLEN      = 64,
    parameter int IMM_W     = 32,
    parameter int NIB_W     = 4
) (
    input  logic [WIN_BYTES*8-1:0]         inst_win,
    input  logic [XLEN-1:0]                port_a_val,
    input  logic [XLEN-1:0]                port_s_val,
    output logic [NIB_W-1:0]               major_op,
    output logic [NIB_W-1:0]               minor_op,
    output logic [NIB_W-1:0]               reg_d,
    output logic [NIB_W-1:0]               reg_s,
    output logic [NIB_W-1:0]               reg_z,
    output logic [NIB_W-1:0]               shift_amt,
    output logic [NIB_W-1:0]               port_a_sel,
    output logic [XLEN-1:0]                imm_sext,
    output logic [XLEN-1:0]                eff_addr,
    output logic [$clog2(WIN_BYTES+1)-1:0] inst_len,
    output logic                           reg_wr_en,
    output logic                           mem_rd_en,
    output logic                           mem_wr_en,
    output logic                           use_agen,
    output logic                           is_stop,
    output logic                           is_ret,
    output logic                           is_jump,
    output logic                           is_call,
    output logic                           is_cbranch,
    output logic                           illegal
);

    localparam int LEN_W = $clog2(WIN_BYTES+1);

    ctrl_t ctrl;

    // Purpose: fixed nibble positions of the header bytes.
    assign major_op  = inst_win[7:4];
    assign minor_op  = inst_win[3:0];
    assign reg_d     = inst_win[15:12];
    assign reg_s     = inst_win[11:8];
    assign reg_z     = inst_win[23:20];
    assign shift_amt = inst_win[19:16];

    vlid_ctrl_decode u_dec (
        .major (major_op),
        .minor (minor_op),
        .ctrl  (ctrl)
    );

    vlid_imm_select #(
        .WIN_BYTES (WIN_BYTES),
        .IMM_W     (IMM_W),
        .XLEN      (XLEN)
    ) u_imm (
        .win     (inst_win),
        .pos     (ctrl.imm_pos),
        .imm_out (imm_sext)
    );

    vlid_agen #(
        .XLEN (XLEN),
        .SH_W (NIB_W)
    ) u_agen (
        .opnd_a (port_a_val),
        .opnd_s (port_s_val),
        .imm    (imm_sext),
        .shamt  (shift_amt),
        .en_z   (ctrl.use_z),
        .en_s   (ctrl.use_s),
        .en_d   (ctrl.use_d),
        .addr   (eff_addr)
    );

    // Purpose: first read port chooses index or destination register.
    assign port_a_sel = ctrl.sel_z_port ? reg_z : reg_d;

    // Purpose: fan the control bundle out to the ports.
    assign inst_len   = LEN_W'(ctrl.len);
    assign reg_wr_en  = ctrl.reg_wr;
    assign mem_rd_en  = ctrl.mem_rd;
    assign mem_wr_en  = ctrl.mem_wr;
    assign use_agen   = ctrl.use_agen;
    assign is_stop    = ctrl.stop;
    assign is_ret     = ctrl.ret;
    assign is_jump    = ctrl.jump;
    assign is_call    = ctrl.call;
    assign is_cbranch = ctrl.cbranch;
    assign illegal    = ctrl.illegal;

endmodule

// File: rtl/vlid_checker.sv
// Checker: immediate assertions over the top's ports, evaluated whenever
// they change. Assumes it is bound into vlid_decode_agen.
module vlid_checker #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 4
) (
    input logic [3:0]       major_op,
    input logic [3:0]       reg_d,
    input logic [3:0]       reg_z,
    input logic [3:0]       port_a_sel,
    input logic [XLEN-1:0]  imm_sext,
    input logic [XLEN-1:0]  eff_addr,
    input logic [LEN_W-1:0] inst_len,
    input logic             reg_wr_en,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic             use_agen,
    input logic             is_stop,
    input logic             is_ret,
    input logic             is_jump,
    input logic             is_call,
    input logic             is_cbranch,
    input logic             illegal
);

    // Purpose: check cross-module invariants on every input change.
    always_comb begin
        a_r2_illegal_quiet: assert (!illegal ||
            !(reg_wr_en || mem_rd_en || mem_wr_en || use_agen ||
              is_stop || is_ret || is_jump || is_call || is_cbranch))
            else $error("illegal opcode left an enable high");
        a_r10_len_zero_iff_illegal: assert (illegal == (inst_len == '0))
            else $error("length and illegal flag disagree");
        a_r8_ld_st_exclusive: assert (!(mem_rd_en && mem_wr_en))
            else $error("load and store both high");
        a_r9_flow_onehot: assert ($onehot0({is_stop, is_ret, is_jump, is_call, is_cbranch}))
            else $error("more than one flow flag high");
        a_r4_no_agen_zero: assert (use_agen || eff_addr == '0)
            else $error("non-address class produced an address");
        a_r3_sign_copy: assert (imm_sext[XLEN-1:31] == '0 || imm_sext[XLEN-1:31] == '1)
            else $error("immediate upper bits not a sign copy");
        a_r6_port_sel: assert (port_a_sel ==
            ((major_op >= 4'h8 && major_op <= 4'hB) ? reg_z : reg_d))
            else $error("first port selected the wrong field");
    end

endmodule

bind vlid_decode_agen vlid_checker #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_vlid_decode_agen.sv
// Scoreboard bench: the driver applies a window and pushes the expected
// result; the monitor pops and compares half a clock later.
module tb_vlid_decode_agen;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0]  maj, mnr, d, s, z, sh, psel;
        logic [63:0] imm, ea;
        logic [3:0]  len;
        logic        wr, rd, st, ag, stp, rt, jp, cl, cb, ill;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] win = '0;
    logic [63:0] pa = '0;
    logic [63:0] ps = '0;

    logic [3:0]  major_op, minor_op, reg_d, reg_s, reg_z, shift_amt, port_a_sel, inst_len;
    logic [63:0] imm_sext, eff_addr;
    logic        reg_wr_en, mem_rd_en, mem_wr_en, use_agen;
    logic        is_stop, is_ret, is_jump, is_call, is_cbranch, illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    vlid_decode_agen dut (
        .inst_win(win), .port_a_val(pa), .port_s_val(ps),
        .major_op(major_op), .minor_op(minor_op), .reg_d(reg_d), .reg_s(reg_s),
        .reg_z(reg_z), .shift_amt(shift_amt), .port_a_sel(port_a_sel),
        .imm_sext(imm_sext), .eff_addr(eff_addr), .inst_len(inst_len),
        .reg_wr_en(reg_wr_en), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .use_agen(use_agen), .is_stop(is_stop), .is_ret(is_ret), .is_jump(is_jump),
        .is_call(is_call), .is_cbranch(is_cbranch), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic exp_t model(logic [79:0] w, logic [63:0] a, logic [63:0] s);
        exp_t e;
        logic ag_cls;
        int   pos;
        logic [31:0] i32;
        logic [63:0] ta, ts, ti;
        e.maj = w[7:4];  e.mnr = w[3:0];
        e.d   = w[15:12]; e.s  = w[11:8];
        e.z   = w[23:20]; e.sh = w[19:16];
        e.ill = (e.maj == 4'hC) || (e.maj == 4'hD) || (e.maj == 4'hE);
        ag_cls = (e.maj inside {4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB});
        e.ag  = ag_cls;
        pos   = (e.maj == 4'hB) ? 3 : (e.maj == 4'hF) ? 6 : 2;
        i32   = w[pos*8 +: 32];
        e.imm = {{32{i32[31]}}, i32};
        ta = (ag_cls && e.mnr[1]) ? (a << e.sh) : 64'h0;
        ts = (ag_cls && e.mnr[0]) ? s : 64'h0;
        ti = (ag_cls && e.mnr[2]) ? e.imm : 64'h0;
        e.ea   = ta + ts + ti;
        e.psel = (e.maj >= 4'h8 && e.maj <= 4'hB) ? e.z : e.d;
        e.rd   = (e.maj == 4'h3 || e.maj == 4'h7) && !e.mnr[3];
        e.st   = (e.maj == 4'h3 || e.maj == 4'h7) && e.mnr[3];
        e.stp  = (e.maj == 4'h0) && (e.mnr == 4'h0);
        e.rt   = (e.maj == 4'h0) && (e.mnr == 4'h1);
        e.jp   = (e.maj == 4'h4) && (e.mnr == 4'hF);
        e.cl   = (e.maj == 4'h4) && (e.mnr == 4'hE);
        e.cb   = ((e.maj == 4'h4) && (e.mnr != 4'hE) && (e.mnr != 4'hF)) || (e.maj == 4'hF);
        e.wr   = (e.maj inside {4'h1, 4'h2, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB}) || e.rd || e.cl;
        case (e.maj)
            4'h0, 4'h1, 4'h2, 4'h3: e.len = 4'd2;
            4'h8:                   e.len = 4'd3;
            4'hB:                   e.len = 4'd7;
            4'hF:                   e.len = 4'd10;
            4'hC, 4'hD, 4'hE:       e.len = 4'd0;
            default:                e.len = 4'd6;
        endcase
        return e;
    endfunction

    function automatic logic [79:0] mkw(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                                        int pos, logic [31:0] imm);
        logic [79:0] w;
        w = {56'h0, b2, b1, b0};
        if (pos > 0) w[pos*8 +: 32] = imm;
        return w;
    endfunction

    task automatic drive(logic [79:0] w, logic [63:0] a, logic [63:0] s);
        @(posedge clk);
        win = w; pa = a; ps = s;
        q.push_back(model(w, a, s));
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (win=%h)", tag, act, exp, win);
        end
    endtask

    // Monitor: compare outputs half a cycle after each applied window.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R1 fields", {40'h0, major_op, minor_op, reg_d, reg_s, reg_z, shift_amt},
                {40'h0, e.maj, e.mnr, e.d, e.s, e.z, e.sh});
            chk("R2 illegal", {63'h0, illegal}, {63'h0, e.ill});
            chk("R3 immediate", imm_sext, e.imm);
            chk("R4 use_agen", {63'h0, use_agen}, {63'h0, e.ag});
            chk("R5 eff_addr", eff_addr, e.ea);
            chk("R6 port_a_sel", {60'h0, port_a_sel}, {60'h0, e.psel});
            chk("R7 reg_wr_en", {63'h0, reg_wr_en}, {63'h0, e.wr});
            chk("R8 mem enables", {62'h0, mem_rd_en, mem_wr_en}, {62'h0, e.rd, e.st});
            chk("R9 flow flags", {59'h0, is_stop, is_ret, is_jump, is_call, is_cbranch},
                {59'h0, e.stp, e.rt, e.jp, e.cl, e.cb});
            chk("R10 inst_len", {60'h0, inst_len}, {60'h0, e.len});
        end
    end

    // Driver: directed corner cases, then a pseudo-random sweep.
    initial begin
        logic [63:0] st;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9 all-zero window after reset decodes as stop
        drive(80'h0, 64'h0, 64'h0);
        drive(mkw(8'h01, 8'h00, 8'h00, 0, 0), 64'h0, 64'h0);                  // R9 return
        drive(mkw(8'h10, 8'h3A, 8'h00, 0, 0), 64'h5, 64'h6);                  // R7 reg arith
        drive(mkw(8'h83, 8'h12, 8'h54, 0, 0), 64'h10, 64'h7);                 // R4 R5 z<<4 + s
        drive(mkw(8'h95, 8'h12, 8'h00, 2, 32'hFFFF_FFF0), 64'h9, 64'h1000);   // R3 negative imm + s
        drive(mkw(8'hB7, 8'h12, 8'h31, 3, 32'h0000_0100), 64'h2, 64'h4);      // R3 byte 3
        drive(mkw(8'hF1, 8'h45, 8'hAA, 6, 32'h8000_0000), 64'h1, 64'h2);      // R3 byte 6
        drive(mkw(8'hC3, 8'h12, 8'h34, 0, 0), 64'hFF, 64'hFF);                // R2 illegal C
        drive(mkw(8'hD7, 8'h12, 8'h34, 0, 0), 64'hFF, 64'hFF);                // R2 illegal D
        drive(mkw(8'hEF, 8'h12, 8'h34, 0, 0), 64'hFF, 64'hFF);                // R2 illegal E
        drive(mkw(8'h31, 8'h12, 8'h00, 0, 0), 64'h0, 64'h800);                // R8 load
        drive(mkw(8'h39, 8'h12, 8'h00, 0, 0), 64'h0, 64'h800);                // R8 store
        drive(mkw(8'h4E, 8'h00, 8'h00, 2, 32'h40), 64'h0, 64'h0);             // R9 call
        drive(mkw(8'h4F, 8'h00, 8'h00, 2, 32'h40), 64'h0, 64'h0);             // R9 jump
        drive(mkw(8'h41, 8'h12, 8'h00, 2, 32'h40), 64'h0, 64'h0);             // R9 cond branch
        drive(mkw(8'h83, 8'h12, 8'h5F, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1); // R5 wraparound
        drive(mkw(8'h64, 8'h20, 8'h00, 2, 32'h7FFF_FFFF), 64'h0, 64'h0);      // R3 R4 imm move
        st = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 320; i++) begin
            logic [79:0] w;
            logic [63:0] a;
            st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
            w[63:0] = st;
            a = {st[31:0], st[63:32]};
            st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
            w[79:64] = st[15:0];
            w[7:4] = 4'(i);
            drive(w, a, st);
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL all watchdog actual=running expected=finished");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule